// File: doc/BRIEF.md
# Configurable Logic Cell Register

This block is the output stage of one programmable logic cell. It receives a sum-of-products term from the logic array and a value taken straight from an input pin. A set of static configuration inputs shapes what the cell does with them. It can pass the chosen data straight to the output as plain combinational logic. It can also store that data in a single bit that acts as a D flip-flop, a toggle flip-flop or a transparent latch. The storing clock is one of several global clocks or a locally formed clock, and the cell can update on one edge or on both edges.

All logic runs from one fast system clock `clk`. The cell clocks are sampled as ordinary inputs and their edges are found by comparing each level with the level from the previous system cycle. The asynchronous controls override the output combinationally in the same cycle they are asserted. They also load the forced value into the stored bit at the next system edge, so it is still there after they release. A feedback output carries the same value as the cell output back towards the array.

Top module: `lcell_reg`

## Requirements
- R1: With `cfgRegMode`=0 the cell is combinational: `cellOut` equals the selected data input in the same cycle, and no set, reset or clock input changes it.
- R2: The selected data is `pinIn` when `cfgDirect`=1 and `sopIn` when `cfgDirect`=0.
- R3: With `cfgStore`=0 (D flip-flop; the value 3 also behaves as 0), the stored bit takes the selected data on each active clock edge while `clkEn`=1. The new value shows on `cellOut` after the system edge that samples the cell clock edge.
- R4: With `cfgStore`=1 (toggle), an enabled active edge inverts the stored bit when the data is 1 and keeps it when the data is 0.
- R5: With `cfgStore`=2 (latch), while `clkEn`=1 and the effective clock is high, `cellOut` follows the data in the same cycle. Otherwise it holds the last value it passed.
- R6: With `cfgDualEdge`=1 both the rising and the falling edge of the effective clock are active. With `cfgDualEdge`=0 only the rising edge is active.
- R7: `cfgClkSel` values 0 to 2 choose `globalClk[0..2]`, and the value 3 chooses `localClk`. `cfgClkInvert`=1 inverts a global clock before edge detection and has no effect on the local clock.
- R8: While `clkEn`=0 the stored bit holds through any clock edges.
- R9: While `globalSetRst`=1 a registered cell outputs `cfgGlobalToOne` immediately, whatever the local controls are doing. The forced value stays stored after release.
- R10: While `globalSetRst`=0, `localRst`=1 forces 0 and otherwise `localSet`=1 forces 1. Both act immediately, reset wins over set, and the forced value stays stored after release.
- R11: While `rstN`=0 the stored bit loads `cfgInitVal`. No clock edge is recognised in the first system cycle after release.
- R12: `feedbackOut` always equals `cellOut`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all cell clocks |
| rstN | input | 1 | Active-low initialisation; loads the power-up value |
| cfgRegMode | input | 1 | 1 = registered path, 0 = combinational |
| cfgStore | input | 2 | Storage kind: 0 D, 1 toggle, 2 latch |
| cfgDualEdge | input | 1 | 1 = update on both edges |
| cfgClkSel | input | 2 | Clock source: 0..2 global, 3 local |
| cfgClkInvert | input | 1 | Phase inversion of the chosen global clock |
| cfgGlobalToOne | input | 1 | 1 = global line sets, 0 = it clears |
| cfgInitVal | input | 1 | Power-up value of the stored bit |
| cfgDirect | input | 1 | 1 = store the pin input instead of the array term |
| globalClk | input | 3 | Global cell clocks |
| localClk | input | 1 | Locally formed cell clock |
| clkEn | input | 1 | Synchronous clock enable |
| globalSetRst | input | 1 | Chip-wide asynchronous set/clear |
| localSet | input | 1 | Per-cell asynchronous set |
| localRst | input | 1 | Per-cell asynchronous reset |
| sopIn | input | 1 | Sum-of-products data from the array |
| pinIn | input | 1 | Data taken directly from the pin |
| cellOut | output | 1 | Cell output |
| feedbackOut | output | 1 | Copy of the output for the array |

## Verification
The bench sweeps every storage kind, both edge modes, all four clock sources and both phases. It drives toggling noise on the clocks that are not selected, so a wrong mux choice or an ignored inversion captures on the wrong edge and the output drifts from the bench model. A toggle cell that loaded instead of inverting, or a latch that captured only at edges, would miss the values the model predicts. Directed checks assert the global and local controls together: a design with reversed priority would output the local value instead of the global one, or 1 instead of 0. A forced value that was not written into the bit would be lost once the controls release. The reset is held with the clock already high, so a design that saw a spurious first edge would replace the power-up value.

// File: rtl/lcell_pkg.sv
package lcell_pkg;

  // Storage element kinds chosen by the static configuration
  typedef enum logic [1:0] {
    ST_DFF   = 2'd0,
    ST_TFF   = 2'd1,
    ST_LATCH = 2'd2,
    ST_SPARE = 2'd3
  } storeKind_t;

  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic loadEn;     // capture data into the bit
    logic toggleEn;   // invert the bit when data is 1
    logic latchOpen;  // latch is transparent this cycle
    logic forceEn;    // an asynchronous override is active
    logic forceVal;   // value the override imposes
  } cellStrobes_t;

endpackage

// File: rtl/lcell_ctrl.sv
module lcell_ctrl
  import lcell_pkg::*;
#(
  parameter int NUM_GCLK = 3,
  parameter int SEL_W    = $clog2(NUM_GCLK + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [1:0]          cfgStore,
  input  logic                cfgDualEdge,
  input  logic [SEL_W-1:0]    cfgClkSel,
  input  logic                cfgClkInvert,
  input  logic                cfgGlobalToOne,
  input  logic [NUM_GCLK-1:0] globalClk,
  input  logic                localClk,
  input  logic                clkEn,
  input  logic                globalSetRst,
  input  logic                localSet,
  input  logic                localRst,
  output cellStrobes_t        strobes
);

  storeKind_t kind;
  logic [NUM_GCLK-1:0] hitGlobal;
  logic rawClk;
  logic isGlobal;
  logic selClk;
  logic prevClk;
  logic primed;
  logic riseEv;
  logic fallEv;
  logic activeEv;
  logic edgeOk;
  logic forceAny;

  assign kind = storeKind_t'(cfgStore);

  // one match line per global clock
  for (genvar g = 0; g < NUM_GCLK; g++) begin : g_sel
    assign hitGlobal[g] = (cfgClkSel == SEL_W'(g));
  end

  always_comb begin
    rawClk   = localClk;
    isGlobal = 1'b0;
    for (int i = 0; i < NUM_GCLK; i++) begin
      if (hitGlobal[i]) begin
        rawClk   = globalClk[i];
        isGlobal = 1'b1;
      end
    end
  end

  // phase choice only applies to the global clocks
  assign selClk = rawClk ^ (isGlobal & cfgClkInvert);

  always_ff @(posedge clk) begin
    prevClk <= selClk;
    if (!rstN) primed <= 1'b0;
    else       primed <= 1'b1;
  end

  assign riseEv   = primed & selClk & ~prevClk;
  assign fallEv   = primed & ~selClk & prevClk;
  assign activeEv = cfgDualEdge ? (riseEv | fallEv) : riseEv;

  assign forceAny = globalSetRst | localRst | localSet;
  assign edgeOk   = clkEn & activeEv & ~forceAny;

  always_comb begin
    strobes.forceEn = forceAny;
    if (globalSetRst)  strobes.forceVal = cfgGlobalToOne;
    else if (localRst) strobes.forceVal = 1'b0;
    else               strobes.forceVal = 1'b1;
    strobes.loadEn    = 1'b0;
    strobes.toggleEn  = 1'b0;
    strobes.latchOpen = 1'b0;
    unique case (kind)
      ST_TFF:   strobes.toggleEn  = edgeOk;
      ST_LATCH: strobes.latchOpen = clkEn & selClk & ~forceAny;
      default:  strobes.loadEn    = edgeOk;
    endcase
  end

endmodule

// File: rtl/lcell_datapath.sv
module lcell_datapath
  import lcell_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         cfgRegMode,
  input  logic         cfgDirect,
  input  logic         cfgInitVal,
  input  logic         sopIn,
  input  logic         pinIn,
  input  cellStrobes_t strobes,
  output logic         cellOut,
  output logic         feedbackOut
);

  logic dataIn;
  logic storedBit;
  logic nextBit;
  logic regView;

  assign dataIn = cfgDirect ? pinIn : sopIn;

  always_comb begin
    if (strobes.forceEn)        nextBit = strobes.forceVal;
    else if (strobes.loadEn)    nextBit = dataIn;
    else if (strobes.toggleEn)  nextBit = storedBit ^ dataIn;
    else if (strobes.latchOpen) nextBit = dataIn;
    else                        nextBit = storedBit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) storedBit <= cfgInitVal;
    else       storedBit <= nextBit;
  end

  // overrides and the open latch show without waiting for a clock
  always_comb begin
    if (strobes.forceEn)        regView = strobes.forceVal;
    else if (strobes.latchOpen) regView = dataIn;
    else                        regView = storedBit;
  end

  assign cellOut     = cfgRegMode ? regView : dataIn;
  assign feedbackOut = cellOut;

endmodule

// File: rtl/lcell_reg.sv
module lcell_reg
  import lcell_pkg::*;
#(
  parameter int NUM_GCLK = 3,
  parameter int SEL_W    = $clog2(NUM_GCLK + 1)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgRegMode,
  input  logic [1:0]          cfgStore,
  input  logic                cfgDualEdge,
  input  logic [SEL_W-1:0]    cfgClkSel,
  input  logic                cfgClkInvert,
  input  logic                cfgGlobalToOne,
  input  logic                cfgInitVal,
  input  logic                cfgDirect,
  input  logic [NUM_GCLK-1:0] globalClk,
  input  logic                localClk,
  input  logic                clkEn,
  input  logic                globalSetRst,
  input  logic                localSet,
  input  logic                localRst,
  input  logic                sopIn,
  input  logic                pinIn,
  output logic                cellOut,
  output logic                feedbackOut
);

  cellStrobes_t strobes;

  lcell_ctrl #(.NUM_GCLK(NUM_GCLK), .SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgStore(cfgStore), .cfgDualEdge(cfgDualEdge),
    .cfgClkSel(cfgClkSel), .cfgClkInvert(cfgClkInvert),
    .cfgGlobalToOne(cfgGlobalToOne), .globalClk(globalClk),
    .localClk(localClk), .clkEn(clkEn), .globalSetRst(globalSetRst),
    .localSet(localSet), .localRst(localRst), .strobes(strobes)
  );

  lcell_datapath u_dp (
    .clk(clk), .rstN(rstN), .cfgRegMode(cfgRegMode), .cfgDirect(cfgDirect),
    .cfgInitVal(cfgInitVal), .sopIn(sopIn), .pinIn(pinIn),
    .strobes(strobes), .cellOut(cellOut), .feedbackOut(feedbackOut)
  );

endmodule

// File: rtl/lcell_reg_checker.sv
module lcell_reg_checker (
  input logic       clk,
  input logic       rstN,
  input logic       cfgRegMode,
  input logic [1:0] cfgStore,
  input logic       cfgGlobalToOne,
  input logic       cfgDirect,
  input logic       clkEn,
  input logic       globalSetRst,
  input logic       localSet,
  input logic       localRst,
  input logic       sopIn,
  input logic       pinIn,
  input logic       cellOut,
  input logic       feedbackOut
);

  p_comb_path_r1: assert property (@(posedge clk) disable iff (!rstN)
    !cfgRegMode |-> (cellOut == (cfgDirect ? pinIn : sopIn)));

  p_hold_no_en_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRegMode && cfgStore != 2'd2 && !clkEn && !globalSetRst && !localRst && !localSet)
    |=> (globalSetRst || localRst || localSet || $stable(cellOut)));

  p_global_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRegMode && globalSetRst) |-> (cellOut == cfgGlobalToOne));

  p_reset_wins_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRegMode && !globalSetRst && localRst) |-> !cellOut);

  p_set_alone_r10: assert property (@(posedge clk) disable iff (!rstN)
    (cfgRegMode && !globalSetRst && !localRst && localSet) |-> cellOut);

  p_feedback_r12: assert property (@(posedge clk) disable iff (!rstN)
    feedbackOut == cellOut);

endmodule

bind lcell_reg lcell_reg_checker u_chk (
  .clk(clk), .rstN(rstN), .cfgRegMode(cfgRegMode), .cfgStore(cfgStore),
  .cfgGlobalToOne(cfgGlobalToOne), .cfgDirect(cfgDirect), .clkEn(clkEn),
  .globalSetRst(globalSetRst), .localSet(localSet), .localRst(localRst),
  .sopIn(sopIn), .pinIn(pinIn), .cellOut(cellOut), .feedbackOut(feedbackOut)
);

// File: tb/lcell_reg_test.sv
`timescale 1ns/1ps
module lcell_reg_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgRegMode = 1'b1;
  logic [1:0] cfgStore = 2'd0;
  logic       cfgDualEdge = 1'b0;
  logic [1:0] cfgClkSel = 2'd0;
  logic       cfgClkInvert = 1'b0;
  logic       cfgGlobalToOne = 1'b0;
  logic       cfgInitVal = 1'b0;
  logic       cfgDirect = 1'b0;
  logic [2:0] globalClk = 3'b000;
  logic       localClk = 1'b0;
  logic       clkEn = 1'b1;
  logic       globalSetRst = 1'b0;
  logic       localSet = 1'b0;
  logic       localRst = 1'b0;
  logic       sopIn = 1'b0;
  logic       pinIn = 1'b0;
  logic       cellOut;
  logic       feedbackOut;

  int checks = 0;
  int errors = 0;
  logic mQ;
  logic mPrev;
  logic [7:0] lfsr = 8'hA5;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  lcell_reg uut (
    .clk(clk), .rstN(rstN), .cfgRegMode(cfgRegMode), .cfgStore(cfgStore),
    .cfgDualEdge(cfgDualEdge), .cfgClkSel(cfgClkSel), .cfgClkInvert(cfgClkInvert),
    .cfgGlobalToOne(cfgGlobalToOne), .cfgInitVal(cfgInitVal), .cfgDirect(cfgDirect),
    .globalClk(globalClk), .localClk(localClk), .clkEn(clkEn),
    .globalSetRst(globalSetRst), .localSet(localSet), .localRst(localRst),
    .sopIn(sopIn), .pinIn(pinIn), .cellOut(cellOut), .feedbackOut(feedbackOut)
  );

  task automatic check(input logic got, input logic exp, input string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b (store=%0d dual=%0b sel=%0d inv=%0b)",
               req, got, exp, cfgStore, cfgDualEdge, cfgClkSel, cfgClkInvert);
    end
  endtask

  // drive the selected clock to effective level e, noise on the others
  task automatic driveClocks(input logic e, input int i);
    for (int g = 0; g < 3; g++)
      globalClk[g] = (cfgClkSel == 2'(g)) ? (e ^ cfgClkInvert) : i[0];
    localClk = (cfgClkSel == 2'd3) ? e : ~i[0];
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    driveClocks(1'b0, 0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #2;
    check(cellOut, cfgInitVal, "R11 init value");
    mQ = cfgInitVal;
    mPrev = 1'b0;
  endtask

  task automatic runStep(input logic e, input logic sop, input logic pin,
                         input logic en, input int i, input string tag);
    logic d, rise, fall, act, expOut;
    @(negedge clk);
    sopIn = sop;
    pinIn = pin;
    clkEn = en;
    driveClocks(e, i);
    @(posedge clk);
    #2;
    d = cfgDirect ? pin : sop;
    rise = e & ~mPrev;
    fall = ~e & mPrev;
    act = cfgDualEdge ? (rise | fall) : rise;
    case (cfgStore)
      2'd1: if (en && act) mQ = mQ ^ d;
      2'd2: if (en && e) mQ = d;
      default: if (en && act) mQ = d;
    endcase
    mPrev = e;
    expOut = (cfgStore == 2'd2 && en && e) ? d : mQ;
    check(cellOut, expOut, tag);
    check(feedbackOut, cellOut, "R12 feedback");
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // R1/R2: combinational mode, controls and clocks have no effect
    cfgRegMode = 1'b0;
    rstN = 1'b1;
    for (int v = 0; v < 16; v++) begin
      @(negedge clk);
      sopIn = v[0];
      pinIn = v[1];
      cfgDirect = v[2];
      globalSetRst = v[3];
      localSet = v[3];
      globalClk = v[2:0];
      #1;
      check(cellOut, v[2] ? v[1] : v[0], "R1 R2 combinational");
    end
    globalSetRst = 1'b0;
    localSet = 1'b0;
    cfgRegMode = 1'b1;

    // near-exhaustive sweep of registered configurations
    for (int st = 0; st < 3; st++)
      for (int du = 0; du < 2; du++)
        for (int se = 0; se < 4; se++)
          for (int iv = 0; iv < 2; iv++)
            for (int in = 0; in < 2; in++) begin
              string tag;
              cfgStore = 2'(st);
              cfgDualEdge = du[0];
              cfgClkSel = 2'(se);
              cfgClkInvert = iv[0];
              cfgInitVal = in[0];
              cfgDirect = se[0] ^ in[0];
              tag = $sformatf("%s R2 R6 R7 R8", st == 0 ? "R3" : (st == 1 ? "R4" : "R5"));
              doReset();
              for (int i = 0; i < 24; i++) begin
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                runStep(((i >> 1) & 1) != 0, lfsr[0], lfsr[3], (i % 5) != 4, i, tag);
              end
            end

    // R11: reset held with clock high; first cycle sees no edge
    cfgStore = 2'd0; cfgDualEdge = 1'b0; cfgClkSel = 2'd1; cfgClkInvert = 1'b0;
    cfgInitVal = 1'b1; cfgDirect = 1'b0; clkEn = 1'b1; sopIn = 1'b0;
    @(negedge clk);
    rstN = 1'b0;
    globalClk = 3'b010;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #2;
    check(cellOut, 1'b1, "R11 no edge after release");
    @(negedge clk); globalClk = 3'b000;
    @(negedge clk); globalClk = 3'b010;
    @(posedge clk); #2;
    check(cellOut, 1'b0, "R3 R11 first real edge");

    // R9/R10: override priorities and retention
    cfgGlobalToOne = 1'b1;
    @(negedge clk);
    globalSetRst = 1'b1; localRst = 1'b1;
    #1;
    check(cellOut, 1'b1, "R9 global over local reset");
    @(negedge clk);
    globalSetRst = 1'b0; localSet = 1'b1;
    #1;
    check(cellOut, 1'b0, "R10 reset over set");
    @(negedge clk);
    localRst = 1'b0;
    #1;
    check(cellOut, 1'b1, "R10 set alone");
    @(negedge clk);
    localSet = 1'b0;
    @(posedge clk); #2;
    check(cellOut, 1'b1, "R10 set retained");
    @(negedge clk);
    cfgGlobalToOne = 1'b0; globalSetRst = 1'b1; localSet = 1'b1;
    #1;
    check(cellOut, 1'b0, "R9 global clears over local set");
    @(negedge clk);
    globalSetRst = 1'b0; localSet = 1'b0;
    @(posedge clk); #2;
    check(cellOut, 1'b0, "R9 clear retained");
    check(feedbackOut, cellOut, "R12 feedback");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule